// File: doc/BRIEF.md
# Prioritised Interrupt Acceptance Unit

This block sits beside a small accumulator CPU and decides when that CPU may be interrupted and where it goes when it is. Four timer events (called timer 3 to timer 6) and a parameterised number of external event lines are watched for rising edges. Each edge sets a pending bit, which stays set until that source is served. The highest-priority pending source is offered to the CPU, but only at an instruction boundary, with the global enable set, and with no multi-word instruction and no unresolved skip in flight.

When a source is accepted, the block issues a one-cycle take pulse. In the same cycle it raises a save strobe, which tells the CPU to store its program counter and accumulator without any program action, and presents the vector address of the source. It then stays in service and offers nothing more until the CPU pulses resume. The CPU sends that pulse when it executes its return instruction and restores what was saved. Requests that arrive during service, while interrupts are disabled, or in a blocked window are held and served later, one at a time, in priority order.

Top module: `irq_vector_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, `take_o`, `save_o` and `busy_o` are low after that edge, `vector_o` is zero, and all pending bits are cleared.
- R2: A request line is latched into its pending bit only on a rising edge, meaning high at a clock edge after being low at the previous one. A line held high does not latch again after it is served.
- R3: Fixed priority, highest first: timer 6, timer 5, timer 4, timer 3, then external lines 0 upward. On `tmr_req_i`, bit 3 is timer 6 and bit 0 is timer 3.
- R4: The vector index follows the priority position: timer 6 is 0, timer 5 is 1, timer 4 is 2, timer 3 is 3, and external line k is 4+k. `vector_o` equals `VEC_BASE + 4*index`.
- R5: Acceptance is registered. A request whose rising edge is sampled at edge n, with acceptance allowed at edge n+1, gives `take_o` and `save_o` high together for exactly the one cycle after edge n+1, with `vector_o` valid in that cycle.
- R6: With `glb_en_i` low, nothing is accepted, but requests still latch and are served once it is set.
- R7: While `multi_word_i` is high, nothing is accepted.
- R8: While `skip_pend_i` is high, nothing is accepted.
- R9: Acceptance occurs only at an edge where `insn_bound_i` is high.
- R10: From acceptance until a clock edge samples `resume_i` high, `busy_o` is high and no further acceptance happens. The next acceptance can occur at the edge after the one that samples resume.
- R11: Acceptance clears only the served source's pending bit. Requests arriving in the same cycle are all latched and served one per resume, in priority order, with no extra acceptances afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tmr_req_i | input | 4 | Timer event requests, bit 3 = timer 6 ... bit 0 = timer 3 |
| ext_req_i | input | N_EXT | External event requests |
| glb_en_i | input | 1 | Global interrupt enable |
| insn_bound_i | input | 1 | CPU is at an instruction boundary |
| multi_word_i | input | 1 | A multi-word instruction is in progress |
| skip_pend_i | input | 1 | A skip has not yet resolved |
| resume_i | input | 1 | Return from interrupt executed |
| take_o | output | 1 | One-cycle pulse: interrupt accepted |
| save_o | output | 1 | One-cycle strobe: CPU saves PC and accumulator |
| vector_o | output | ADDR_W | Vector address of the accepted source |
| busy_o | output | 1 | Interrupt in service |

## Verification
The hardest state to reach is a backlog of several pending sources with service blocked. It shows whether the block serves one source per resume, in strict order, and clears only the bit it served. The stimulus raises every non-empty subset of the eight sources within a single cycle, then walks the service chain resume by resume, comparing each vector with the value computed from the subset. A second sweep holds a request behind every combination of enable, boundary, multi-word and skip. It then opens the gates, which shows that the request was kept pending rather than dropped.

// File: rtl/irq_pkg.sv
// Package: shared constants for the interrupt acceptance unit.
// Assumes timer sources always occupy the top four priority slots.
package irq_pkg;
    localparam int unsigned N_TIMER    = 4;
    localparam int unsigned VEC_STRIDE = 4;

    typedef enum logic {
        SVC_IDLE = 1'b0,
        SVC_BUSY = 1'b1
    } svc_state_t;
endpackage

// File: rtl/irq_edge_latch.sv
// Module: irq_edge_latch
// Turns rising edges on N request lines into sticky pending bits.
// Assumes requests are synchronous to clk; a new edge wins over a clear
// in the same cycle, so no edge is lost.
module irq_edge_latch #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);
    logic [N-1:0] prev_q;
    logic [N-1:0] pend_q;

    for (genvar g = 0; g < N; g++) begin : g_src
        // Track each line's previous level and hold its pending bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prev_q[g] <= 1'b0;
                pend_q[g] <= 1'b0;
            end else begin
                prev_q[g] <= req_i[g];
                if (req_i[g] && !prev_q[g]) begin
                    pend_q[g] <= 1'b1;
                end else if (clr_i[g]) begin
                    pend_q[g] <= 1'b0;
                end
            end
        end

        // R2: a rising request is pending one edge later
        p_edge_latches_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (req_i[g] && !prev_q[g]) |=> pend_q[g]);

        // R11: a pending bit only drops when its own clear was given
        p_clear_own_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_q[g] && !clr_i[g]) |=> pend_q[g]);
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/irq_prio_pick.sv
// Module: irq_prio_pick
// Fixed-priority selector: the lowest set index wins.
// Assumes index order already equals priority order.
module irq_prio_pick #(
    parameter int unsigned N     = 8,
    parameter int unsigned IDX_W = 3
) (
    input  logic [N-1:0]     pend_i,
    output logic [N-1:0]     grant_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             valid_o
);
    // Scan from the lowest to the highest priority so the best one wins last.
    always_comb begin
        grant_o = '0;
        idx_o   = '0;
        valid_o = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                grant_o = '0;
                grant_o[i] = 1'b1;
                idx_o   = IDX_W'(i);
                valid_o = 1'b1;
            end
        end
    end

    // R3: at most one grant, and only on a pending source
    always_comb begin
        p_grant_onehot_r3: assert ($onehot0(grant_o));
        p_grant_pending_r3: assert ((grant_o & ~pend_i) == '0);
    end
endmodule

// File: rtl/irq_accept_ctrl.sv
// Module: irq_accept_ctrl
// Decides the acceptance cycle, registers take/save/vector and holds the
// in-service state until resume. Assumes the CPU status lines are valid
// every cycle and resume is a single-cycle pulse.
module irq_accept_ctrl
    import irq_pkg::*;
#(
    parameter int unsigned IDX_W    = 3,
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned VEC_BASE = 'h040
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic              glb_en_i,
    input  logic              insn_bound_i,
    input  logic              multi_word_i,
    input  logic              skip_pend_i,
    input  logic              resume_i,
    output logic              accept_o,
    output logic              take_o,
    output logic              save_o,
    output logic [ADDR_W-1:0] vector_o,
    output logic              busy_o
);
    svc_state_t        state_q;
    logic              take_q;
    logic [ADDR_W-1:0] vec_q;
    logic              gate_open;

    // Combine every inhibit rule into a single permission.
    always_comb begin
        gate_open = glb_en_i && insn_bound_i && !multi_word_i && !skip_pend_i;
        accept_o  = valid_i && gate_open && (state_q == SVC_IDLE);
    end

    // Move between idle and in-service on accept and resume.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SVC_IDLE;
        end else if (accept_o) begin
            state_q <= SVC_BUSY;
        end else if (resume_i) begin
            state_q <= SVC_IDLE;
        end
    end

    // Register the take pulse and the vector of the accepted source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_q <= 1'b0;
            vec_q  <= '0;
        end else begin
            take_q <= accept_o;
            if (accept_o) begin
                vec_q <= ADDR_W'(VEC_BASE) + ADDR_W'(ADDR_W'(idx_i) * VEC_STRIDE);
            end
        end
    end

    assign take_o   = take_q;
    assign save_o   = take_q;
    assign vector_o = vec_q;
    assign busy_o   = (state_q == SVC_BUSY);

    // R6/R7/R8/R9: a take only follows a cycle where every gate was open
    p_gates_open_r9: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> $past(glb_en_i && insn_bound_i && !multi_word_i && !skip_pend_i));

    // R10: in service without resume means no new take next cycle
    p_hold_until_resume_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !resume_i) |=> !take_o);

    // R5: take is a single-cycle pulse
    p_take_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !take_o);
endmodule

// File: rtl/irq_vector_ctrl.sv
// Module: irq_vector_ctrl (top)
// Interrupt acceptance unit: maps timer and external lines into priority
// order, latches edges, picks the winner and hands it to the acceptance
// control. Assumes all inputs are synchronous to clk.
module irq_vector_ctrl
    import irq_pkg::*;
#(
    parameter int unsigned N_EXT    = 4,
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned VEC_BASE = 'h040
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        tmr_req_i,
    input  logic [N_EXT-1:0]  ext_req_i,
    input  logic              glb_en_i,
    input  logic              insn_bound_i,
    input  logic              multi_word_i,
    input  logic              skip_pend_i,
    input  logic              resume_i,
    output logic              take_o,
    output logic              save_o,
    output logic [ADDR_W-1:0] vector_o,
    output logic              busy_o
);
    localparam int unsigned N_SRC = N_TIMER + N_EXT;
    localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

    logic [N_SRC-1:0] src_req;
    logic [N_SRC-1:0] pend;
    logic [N_SRC-1:0] grant;
    logic [N_SRC-1:0] clr;
    logic [IDX_W-1:0] win_idx;
    logic             win_valid;
    logic             accept;

    // Timers go first, highest-numbered timer at slot 0.
    for (genvar t = 0; t < N_TIMER; t++) begin : g_tmr_map
        assign src_req[t] = tmr_req_i[N_TIMER-1-t];
    end
    for (genvar e = 0; e < N_EXT; e++) begin : g_ext_map
        assign src_req[N_TIMER+e] = ext_req_i[e];
    end

    assign clr = grant & {N_SRC{accept}};

    irq_edge_latch #(.N(N_SRC)) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (src_req),
        .clr_i  (clr),
        .pend_o (pend)
    );

    irq_prio_pick #(.N(N_SRC), .IDX_W(IDX_W)) u_pick (
        .pend_i  (pend),
        .grant_o (grant),
        .idx_o   (win_idx),
        .valid_o (win_valid)
    );

    irq_accept_ctrl #(
        .IDX_W    (IDX_W),
        .ADDR_W   (ADDR_W),
        .VEC_BASE (VEC_BASE)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .valid_i      (win_valid),
        .idx_i        (win_idx),
        .glb_en_i     (glb_en_i),
        .insn_bound_i (insn_bound_i),
        .multi_word_i (multi_word_i),
        .skip_pend_i  (skip_pend_i),
        .resume_i     (resume_i),
        .accept_o     (accept),
        .take_o       (take_o),
        .save_o       (save_o),
        .vector_o     (vector_o),
        .busy_o       (busy_o)
    );

    // R4: every vector lies on a stride boundary above the base
    p_vector_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (((vector_o - ADDR_W'(VEC_BASE)) % ADDR_W'(VEC_STRIDE)) == '0));

    // R1: outputs are quiet in the cycle after a reset edge
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!take_o && !busy_o));
endmodule

// File: tb/irq_vector_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_vector_ctrl_tb_top;
    localparam int N_EXT    = 4;
    localparam int ADDR_W   = 12;
    localparam int VEC_BASE = 'h040;
    localparam int N_SRC    = 4 + N_EXT;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [3:0]        tmr_req = '0;
    logic [N_EXT-1:0]  ext_req = '0;
    logic              glb_en = 1'b0;
    logic              bound = 1'b0;
    logic              mw = 1'b0;
    logic              sk = 1'b0;
    logic              resume = 1'b0;
    logic              take;
    logic              save;
    logic [ADDR_W-1:0] vector;
    logic              busy;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    irq_vector_ctrl #(.N_EXT(N_EXT), .ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE)) dut_i (
        .clk(clk), .rst_n(rst_n), .tmr_req_i(tmr_req), .ext_req_i(ext_req),
        .glb_en_i(glb_en), .insn_bound_i(bound), .multi_word_i(mw),
        .skip_pend_i(sk), .resume_i(resume), .take_o(take), .save_o(save),
        .vector_o(vector), .busy_o(busy)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check_eq(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Drive sources by priority position: p<4 is timer (6-p), else ext p-4.
    task automatic set_src(input int mask);
        for (int p = 0; p < N_SRC; p++) begin
            if (p < 4) tmr_req[3-p] = mask[p];
            else       ext_req[p-4] = mask[p];
        end
    endtask

    function automatic int exp_vec(input int p);
        return VEC_BASE + 4 * p;
    endfunction

    task automatic resume_pulse();
        resume = 1'b1;
        step();
        resume = 1'b0;
    endtask

    task automatic open_gates();
        glb_en = 1'b1; bound = 1'b1; mw = 1'b0; sk = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        set_src(8'hFF);
        repeat (3) step();
        check_eq("R1", "take", int'(take), 0);
        check_eq("R1", "save", int'(save), 0);
        check_eq("R1", "busy", int'(busy), 0);
        check_eq("R1", "vector", int'(vector), 0);
        set_src(0);
        step();
        rst_n = 1'b1;
        step();
        step();
        check_eq("R1", "take after release", int'(take), 0);

        // Exhaustive subset sweep: simultaneous arrivals, ordered service.
        open_gates();
        for (int mask = 1; mask < (1 << N_SRC); mask++) begin
            set_src(mask);
            step();
            set_src(0);
            for (int p = 0; p < N_SRC; p++) begin
                if (mask[p]) begin
                    step();
                    check_eq("R5", "take at expected cycle", int'(take), 1);
                    check_eq("R5", "save with take", int'(save), 1);
                    check_eq("R3", "vector in priority order", int'(vector), exp_vec(p));
                    step();
                    check_eq("R5", "take single pulse", int'(take), 0);
                    check_eq("R10", "busy held", int'(busy), 1);
                    step();
                    check_eq("R10", "no take before resume", int'(take), 0);
                    resume_pulse();
                end
            end
            step();
            step();
            check_eq("R11", "no extra take", int'(take), 0);
            check_eq("R10", "idle after resume", int'(busy), 0);
        end

        // Gate sweep: every combination of enable/boundary/multi-word/skip.
        for (int g = 0; g < 16; g++) begin
            automatic int p = g % N_SRC;
            automatic bit allow = g[0] && g[1] && !g[2] && !g[3];
            automatic string tag = !g[0] ? "R6" : (!g[1] ? "R9" : (g[2] ? "R7" : (g[3] ? "R8" : "R4")));
            glb_en = g[0]; bound = g[1]; mw = g[2]; sk = g[3];
            set_src(1 << p);
            step();
            set_src(0);
            step();
            check_eq(tag, "take under gate combo", int'(take), int'(allow));
            if (allow) begin
                check_eq("R4", "vector index", int'(vector), exp_vec(p));
            end else begin
                step();
                check_eq(tag, "still blocked", int'(take), 0);
                open_gates();
                step();
                check_eq(tag, "held request served", int'(take), 1);
                check_eq(tag, "held request vector", int'(vector), exp_vec(p));
            end
            step();
            resume_pulse();
            step();
        end

        // R2: level held high does not latch twice; a new edge does.
        open_gates();
        set_src(1 << 2);
        step();
        step();
        check_eq("R2", "first edge taken", int'(take), 1);
        step();
        resume_pulse();
        step();
        step();
        check_eq("R2", "held level not retaken", int'(take), 0);
        set_src(0);
        step();
        set_src(1 << 2);
        step();
        step();
        check_eq("R2", "new edge taken", int'(take), 1);
        check_eq("R4", "timer 4 vector", int'(vector), exp_vec(2));
        set_src(0);
        step();
        resume_pulse();
        step();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule